// File: doc/BRIEF.md
# Counter Overflow Interrupt Aggregator

This block gathers the overflow state of the programmable event counters numbered 3 to 31 and turns it into one local interrupt. Each counter gives a sticky overflow flag and a single-cycle request pulse. A pulse arrives when that counter wraps while its flag is still clear. Any such pulse sets a shared pending bit. The pending bit stays set until software clears it. The surrounding chip places this bit, and its enable, at position 13 of its interrupt pending and enable registers.

The pending bit is ANDed with an enable input. A delegation input then sends the result to either the machine-level or the supervisor-level interrupt line. The block also produces a 32-bit read-only overflow summary word. Bit X of that word mirrors counter X's flag. Each bit is masked by the privilege mode of the reader and by the per-counter access-enable masks from the machine and hypervisor levels. Supervisor software can therefore find which counters overflowed without calling up to machine mode.

Top module: `cof_irq_aggregator`

## Requirements
- R1: After reset the pending bit reads 0 and both interrupt lines are 0.
- R2: If any of the 29 request pulses is high at a clock edge, the pending bit reads 1 from the next cycle on.
- R3: When no set source is active, the pending bit keeps its value. A software clear with no set source active makes it read 0 from the next cycle on.
- R4: A software set makes the pending bit read 1 on the next cycle. A hardware request or a software set in the same cycle as a software clear leaves the pending bit at 1.
- R5: The machine interrupt line equals pending AND enable AND NOT delegate. The supervisor line equals pending AND enable AND delegate. The two lines are never high together.
- R6: Summary bits 0 to 2 always read 0. Summary bit X, for X from 3 to 31, can only show counter X's flag, which is flag input bit X-3.
- R7: With mode code 2'b11 (machine), every summary bit X from 3 to 31 reads as counter X's flag.
- R8: With mode code 2'b01 (supervisor), summary bit X reads as its flag when machine enable bit X is 1, and reads as 0 otherwise.
- R9: With mode code 2'b10 (virtual supervisor), summary bit X reads as its flag only when both machine and hypervisor enable bit X are 1, and reads as 0 otherwise.
- R10: With mode code 2'b00 (user), the whole summary word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ovf_flag_i | input | 29 | Sticky overflow flags; bit i belongs to counter i+3 |
| ovf_req_i | input | 29 | Overflow interrupt request pulses; bit i belongs to counter i+3 |
| m_cnt_en_i | input | 32 | Machine-level per-counter access enables |
| h_cnt_en_i | input | 32 | Hypervisor-level per-counter access enables |
| priv_mode_i | input | 2 | Reader mode: 11 machine, 01 supervisor, 10 virtual supervisor, 00 user |
| deleg_i | input | 1 | 1 routes the interrupt to supervisor level, 0 to machine level |
| irq_en_i | input | 1 | Interrupt enable bit for this source |
| sw_set_i | input | 1 | Software set of the pending bit |
| sw_clr_i | input | 1 | Software clear of the pending bit |
| pend_o | output | 1 | Count-overflow pending bit |
| irq_m_o | output | 1 | Interrupt to machine level |
| irq_s_o | output | 1 | Interrupt to supervisor level |
| sum_rdata_o | output | 32 | Masked overflow summary word |

## Verification
The hardest case to reach from the ports is a hardware request that lands in the same cycle as a software clear. A free-running stream almost never lines these up while the pending bit is already set. The bench therefore first sets the pending bit, then drives a request pulse and a clear together, and after that drives a clear alone. The summary masks are exercised with walking and complementary enable patterns in each of the four modes, so that every gating path shows both a 0 and a 1. A long seeded random phase follows, with a cycle-by-cycle model.

// File: rtl/cof_pkg.sv
package cof_pkg;
    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_SUP  = 2'b01,
        MODE_VSUP = 2'b10,
        MODE_MACH = 2'b11
    } priv_e;

    typedef struct packed {
        logic pend;
    } pend_state_t;
endpackage

// File: rtl/cof_pend_ctrl.sv
module cof_pend_ctrl #(
    parameter int NUM_REQ = 29
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               sw_set_i,
    input  logic               sw_clr_i,
    output logic               pend_o
);
    import cof_pkg::*;

    pend_state_t st_d, st_q;
    logic        hw_hit;

    always_comb begin
        st_d   = st_q;
        hw_hit = |req_i;
        if (hw_hit || sw_set_i) begin
            st_d.pend = 1'b1;
        end else if (sw_clr_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_req_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|req_i) |=> pend_o);
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|req_i) && !sw_set_i && !sw_clr_i) |=> (pend_o == $past(pend_o)));
    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(|req_i) && !sw_set_i && sw_clr_i) |=> !pend_o);
    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_set_i && sw_clr_i) |=> pend_o);
endmodule

// File: rtl/cof_sum_mask.sv
module cof_sum_mask #(
    parameter int NUM_HPM   = 29,
    parameter int FIRST_HPM = 3,
    localparam int SUM_W    = NUM_HPM + FIRST_HPM
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_HPM-1:0] flag_i,
    input  logic [SUM_W-1:0]   m_en_i,
    input  logic [SUM_W-1:0]   h_en_i,
    input  logic [1:0]         mode_i,
    output logic [SUM_W-1:0]   rdata_o
);
    import cof_pkg::*;

    priv_e            mode;
    logic [SUM_W-1:0] flag_ext;
    logic [SUM_W-1:0] allow;

    assign mode     = priv_e'(mode_i);
    assign flag_ext = {flag_i, {FIRST_HPM{1'b0}}};

    for (genvar g = 0; g < SUM_W; g++) begin : g_bit
        always_comb begin
            unique case (mode)
                MODE_MACH: allow[g] = 1'b1;
                MODE_SUP:  allow[g] = m_en_i[g];
                MODE_VSUP: allow[g] = m_en_i[g] & h_en_i[g];
                default:   allow[g] = 1'b0;
            endcase
        end
        assign rdata_o[g] = flag_ext[g] & allow[g];
    end

    assert_low_bits_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[FIRST_HPM-1:0] == '0);
    assert_subset_of_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[SUM_W-1:FIRST_HPM] & ~flag_i) == '0);
    assert_user_blind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b00) |-> (rdata_o == '0));
    assert_sup_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b01) |-> ((rdata_o & ~m_en_i) == '0));
    assert_vsup_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b10) |-> ((rdata_o & ~(m_en_i & h_en_i)) == '0));
endmodule

// File: rtl/cof_irq_route.sv
module cof_irq_route (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_i,
    input  logic en_i,
    input  logic deleg_i,
    output logic irq_m_o,
    output logic irq_s_o
);
    logic live;

    assign live    = pend_i & en_i;
    assign irq_m_o = live & ~deleg_i;
    assign irq_s_o = live & deleg_i;

    assert_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({irq_m_o, irq_s_o}));
    assert_needs_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_m_o || irq_s_o) |-> pend_i);
endmodule

// File: rtl/cof_irq_aggregator.sv
module cof_irq_aggregator #(
    parameter int NUM_HPM   = 29,
    parameter int FIRST_HPM = 3,
    localparam int SUM_W    = NUM_HPM + FIRST_HPM
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_HPM-1:0] ovf_flag_i,
    input  logic [NUM_HPM-1:0] ovf_req_i,
    input  logic [SUM_W-1:0]   m_cnt_en_i,
    input  logic [SUM_W-1:0]   h_cnt_en_i,
    input  logic [1:0]         priv_mode_i,
    input  logic               deleg_i,
    input  logic               irq_en_i,
    input  logic               sw_set_i,
    input  logic               sw_clr_i,
    output logic               pend_o,
    output logic               irq_m_o,
    output logic               irq_s_o,
    output logic [SUM_W-1:0]   sum_rdata_o
);
    logic pend;

    cof_pend_ctrl #(.NUM_REQ(NUM_HPM)) u_pend (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (ovf_req_i),
        .sw_set_i (sw_set_i),
        .sw_clr_i (sw_clr_i),
        .pend_o   (pend)
    );

    cof_irq_route u_route (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend),
        .en_i    (irq_en_i),
        .deleg_i (deleg_i),
        .irq_m_o (irq_m_o),
        .irq_s_o (irq_s_o)
    );

    cof_sum_mask #(.NUM_HPM(NUM_HPM), .FIRST_HPM(FIRST_HPM)) u_sum (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flag_i  (ovf_flag_i),
        .m_en_i  (m_cnt_en_i),
        .h_en_i  (h_cnt_en_i),
        .mode_i  (priv_mode_i),
        .rdata_o (sum_rdata_o)
    );

    assign pend_o = pend;

    assert_reset_idle_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (!pend_o && !irq_m_o && !irq_s_o));
endmodule

// File: tb/tb_cof_irq_aggregator.sv
module tb_cof_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] flag = '0;
    logic [28:0] req = '0;
    logic [31:0] m_en = '0;
    logic [31:0] h_en = '0;
    logic [1:0]  mode = 2'b11;
    logic        deleg = 1'b0;
    logic        en = 1'b0;
    logic        s_set = 1'b0;
    logic        s_clr = 1'b0;
    logic        pend, irq_m, irq_s;
    logic [31:0] sum;

    int checks = 0;
    int fails = 0;
    logic exp_pend = 1'b0;

    always #5 clk = ~clk;

    cof_irq_aggregator dut (
        .clk_i(clk), .rst_ni(rst_n), .ovf_flag_i(flag), .ovf_req_i(req),
        .m_cnt_en_i(m_en), .h_cnt_en_i(h_en), .priv_mode_i(mode),
        .deleg_i(deleg), .irq_en_i(en), .sw_set_i(s_set), .sw_clr_i(s_clr),
        .pend_o(pend), .irq_m_o(irq_m), .irq_s_o(irq_s), .sum_rdata_o(sum)
    );

    // Behavioural reference of the pending bit.
    always @(posedge clk) begin
        if (!rst_n) exp_pend <= 1'b0;
        else if ((req != '0) || s_set) exp_pend <= 1'b1;
        else if (s_clr) exp_pend <= 1'b0;
    end

    function automatic logic [31:0] exp_sum();
        logic [31:0] r = '0;
        for (int x = 3; x < 32; x++) begin
            bit ok;
            case (mode)
                2'b11: ok = 1;
                2'b01: ok = m_en[x];
                2'b10: ok = m_en[x] && h_en[x];
                default: ok = 0;
            endcase
            r[x] = flag[x-3] && ok;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        string st;
        check("R2/R3 pending bit", {31'b0, pend}, {31'b0, exp_pend});
        check("R5 machine line", {31'b0, irq_m}, {31'b0, exp_pend & en & ~deleg});
        check("R5 supervisor line", {31'b0, irq_s}, {31'b0, exp_pend & en & deleg});
        check("R6 low summary bits", {29'b0, sum[2:0]}, 32'b0);
        case (mode)
            2'b11: st = "R7 machine summary";
            2'b01: st = "R8 supervisor summary";
            2'b10: st = "R9 virtual supervisor summary";
            default: st = "R10 user summary";
        endcase
        check(st, sum, exp_sum());
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        en = 1'b1;
        tick();
        tick();
        check("R1 reset pending", {31'b0, pend}, 32'b0);
        check("R1 reset lines", {30'b0, irq_m, irq_s}, 32'b0);
        rst_n = 1'b1;
        tick();

        // R2: single request pulse
        req = 29'd1 << 5;
        tick();
        req = '0;
        check("R2 set by request", {31'b0, pend}, 32'b1);
        tick();
        check("R3 held", {31'b0, pend}, 32'b1);
        check("R5 to machine", {31'b0, irq_m}, 32'b1);
        deleg = 1'b1;
        tick();
        check("R5 to supervisor", {30'b0, irq_m, irq_s}, 32'b1);
        en = 1'b0;
        tick();
        check("R5 disabled", {30'b0, irq_m, irq_s}, 32'b0);
        en = 1'b1;

        // R3: clear alone
        s_clr = 1'b1;
        tick();
        s_clr = 1'b0;
        check("R3 cleared", {31'b0, pend}, 32'b0);

        // R4: set wins against clear (pending already 1 and from 0)
        s_set = 1'b1;
        tick();
        s_set = 1'b0;
        check("R4 software set", {31'b0, pend}, 32'b1);
        req = 29'd1 << 28;
        s_clr = 1'b1;
        tick();
        check("R4 hw set beats clear (held)", {31'b0, pend}, 32'b1);
        req = '0;
        tick();
        check("R3 clear after collision", {31'b0, pend}, 32'b0);
        req = 29'd1;
        tick();
        check("R4 hw set beats clear (from 0)", {31'b0, pend}, 32'b1);
        req = '0;
        s_clr = 1'b0;

        // Summary masks
        flag = '1;
        mode = 2'b11;
        tick();
        check("R7 all visible", sum, 32'hFFFF_FFF8);
        mode = 2'b01;
        m_en = 32'hAAAA_AAAA;
        tick();
        check("R8 gated by machine mask", sum, 32'hAAAA_AAA8);
        mode = 2'b10;
        h_en = 32'hFFFF_0000;
        tick();
        check("R9 gated by both masks", sum, 32'hAAAA_0000);
        m_en = 32'hFFFF_FFFF;
        h_en = 32'h0F0F_0F0F;
        tick();
        check("R9 hypervisor mask alone", sum, 32'h0F0F_0F08);
        mode = 2'b00;
        tick();
        check("R10 user sees nothing", sum, 32'h0);
        for (int x = 3; x < 32; x++) begin
            flag = 29'd1 << (x - 3);
            mode = 2'b11;
            tick();
            check("R6 bit position", sum, 32'd1 << x);
        end

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            flag  = 29'($urandom);
            m_en  = $urandom;
            h_en  = $urandom;
            mode  = 2'($urandom);
            deleg = 1'($urandom);
            en    = 1'($urandom);
            req   = (($urandom % 8) == 0) ? (29'd1 << ($urandom % 29)) : '0;
            s_set = (($urandom % 16) == 0);
            s_clr = (($urandom % 4) == 0);
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule